// File: doc/BRIEF.md
# Column-Keyed Row Decryption Sequencer

This block reads back one row of an array that stores one ciphertext bit per cell and returns the plaintext in the same pass. Each column is driven by its own key bit. A key of 1 puts the column's drain line at the supply and discharges its sense line. A key of 0 grounds the drain line and charges the sense line to the supply. The row's gate line then gets a read level that sits between the two cell thresholds. A low-threshold cell conducts and copies the drain level onto the sense line. A high-threshold cell does not conduct, so the sense line keeps the level it was charged to. The sensed level is therefore ciphertext XOR key. Because every column carries its own key, a row with mixed key bits needs only one read per column group.

There are fewer sense amplifiers than columns. With the default sizes, 16 sense channels each serve 8 columns, and the sequencer walks through the 8 column groups in turn. In group g, channel s looks at column s*8+g. Each group step has a charge phase and then a read-pulse phase. The channel outputs are captured only at the end of the pulse. Once the last group has been captured, the assembled 128-bit plaintext is flagged valid for one cycle.

Top module: `row_decrypt_seq`

## Requirements
- R1: In a column's group step, key bit 1 gives bl_drive=1 and sl_pre=0, and key bit 0 gives bl_drive=0 and sl_pre=1.
- R2: While idle, and for columns outside the active group, bl_drive and sl_pre are both 0.
- R3: Each plain_row bit equals the cell's ciphertext XOR the key bit latched at start, for any mix of key bits in the row. A sensed 1 is plaintext 1 (low-threshold cell: sense = bl_drive; high-threshold cell: sense = sl_pre).
- R4: grp_sel runs 0,1,…,GROUPS-1 in order. In group g, sense channel s supplies plain_row bit s*GROUPS+g.
- R5: Each group step asserts precharge_en for PRE_CYC cycles (default 1) and then wl_pulse for PULSE_CYC cycles (default 2). The two are never high together.
- R6: sense_in is taken only in the last wl_pulse cycle of a step. Values present in any other cycle have no effect on plain_row.
- R7: plain_valid is high for exactly one cycle, GROUPS*(PRE_CYC+PULSE_CYC) cycles (default 24) after the edge that accepts start. At that point all columns of plain_row hold the new row.
- R8: start is accepted only while busy is low. A start or key_row change while busy neither restarts the sequence nor changes the key in use.
- R9: After reset, busy, plain_valid, precharge_en, wl_pulse, grp_sel, bl_drive, sl_pre and plain_row are all 0.
- R10: busy is high from the cycle after start is accepted through the last capture cycle, and is low in the valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to decrypt a row (taken when idle) |
| key_row | input | COLS | Per-column key bits, latched at start |
| sense_in | input | CHANNELS | Sensed sense-line levels, one per channel |
| busy | output | 1 | Sequence in progress |
| precharge_en | output | 1 | Charge phase of the current group step |
| wl_pulse | output | 1 | Read level on the row's gate line |
| grp_sel | output | GW | Sense-channel column multiplexer select |
| bl_drive | output | COLS | Per-column drain line at supply (1) or ground (0) |
| sl_pre | output | COLS | Per-column sense line charged to supply (1) or ground (0) |
| plain_row | output | COLS | Assembled plaintext word |
| plain_valid | output | 1 | One-cycle flag: plain_row holds a complete row |

## Verification
Two events can fall in the same cycle: the last capture of one row and a new start request. The bench holds start high, with a different key, through the final capture cycle of a row and on into its valid cycle. The request must be ignored in the capture cycle, because the block is still busy. It must then be accepted at the edge that ends the valid cycle, so the next row runs back to back. The bench judges this in two ways. The first row's plaintext must reflect the original key. The second row's bias timing and plaintext must follow the new key, counted from that acceptance edge. A cell model resolves every sense value from the block's own bias outputs, and it returns inverted data in every cycle except the last pulse cycle.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_PULSE = 2'd2
  } phase_t;

  // column served by sense channel ch while group grp is active
  function automatic int unsigned col_index(input int unsigned ch,
                                            input int unsigned grp,
                                            input int unsigned groups);
    return ch * groups + grp;
  endfunction

  // cycles from start acceptance to the valid cycle
  function automatic int unsigned row_latency(input int unsigned groups,
                                              input int unsigned pre_c,
                                              input int unsigned pulse_c);
    return groups * (pre_c + pulse_c);
  endfunction

endpackage

// File: rtl/rdec_phase_ctl.sv
module rdec_phase_ctl
  import rdec_pkg::*;
#(
  parameter int unsigned GROUPS    = 8,
  parameter int unsigned PRE_CYC   = 1,
  parameter int unsigned PULSE_CYC = 2,
  localparam int unsigned GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int unsigned MAXC = (PRE_CYC > PULSE_CYC) ? PRE_CYC : PULSE_CYC,
  localparam int unsigned CW = (MAXC > 1) ? $clog2(MAXC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          precharge_en,
  output logic          wl_pulse,
  output logic [GW-1:0] grp,
  output logic          cap_ev,
  output logic          last_grp
);

  localparam logic [CW-1:0] PRE_LAST   = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [GW-1:0] GRP_LAST   = GW'(GROUPS - 1);

  phase_t        ph;
  logic [CW-1:0] cnt;

  assign busy         = (ph != PH_IDLE);
  assign accept       = (ph == PH_IDLE) && start;
  assign precharge_en = (ph == PH_PRE);
  assign wl_pulse     = (ph == PH_PULSE);
  assign last_grp     = (grp == GRP_LAST);
  assign cap_ev       = wl_pulse && (cnt == PULSE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      grp <= '0;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_PRE;
          grp <= '0;
          cnt <= '0;
        end
        PH_PRE: if (cnt == PRE_LAST) begin
          ph  <= PH_PULSE;
          cnt <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
        PH_PULSE: if (cnt == PULSE_LAST) begin
          cnt <= '0;
          if (last_grp) begin
            ph <= PH_IDLE;
          end else begin
            ph  <= PH_PRE;
            grp <= grp + GW'(1);
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  p_phase_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge_en && wl_pulse));

  p_pulse_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(precharge_en) |-> wl_pulse);

  p_grp_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && !last_grp) |=> (grp == $past(grp) + GW'(1)) && precharge_en);

  p_grp_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (grp == '0));

endmodule

// File: rtl/rdec_bias_drv.sv
module rdec_bias_drv #(
  parameter int unsigned COLS   = 128,
  parameter int unsigned GROUPS = 8,
  localparam int unsigned GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic            active,
  input  logic [GW-1:0]   grp,
  input  logic [COLS-1:0] key,
  output logic [COLS-1:0] bl_drive,
  output logic [COLS-1:0] sl_pre
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int unsigned MYGRP = c % GROUPS;
    logic sel;
    assign sel         = active && (grp == GW'(MYGRP));
    // key 1: drain at supply, sense line discharged; key 0: the reverse
    assign bl_drive[c] = sel &&  key[c];
    assign sl_pre[c]   = sel && !key[c];
  end

endmodule

// File: rtl/rdec_capture.sv
module rdec_capture
  import rdec_pkg::*;
#(
  parameter int unsigned COLS     = 128,
  parameter int unsigned CHANNELS = 16,
  localparam int unsigned GROUPS = COLS / CHANNELS,
  localparam int unsigned GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_ev,
  input  logic [GW-1:0]       grp,
  input  logic [CHANNELS-1:0] sense,
  output logic [COLS-1:0]     plain
);

  for (genvar s = 0; s < CHANNELS; s++) begin : g_ch
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam int unsigned COL = col_index(s, g, GROUPS);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          plain[COL] <= 1'b0;
        else if (cap_ev && (grp == GW'(g)))
          plain[COL] <= sense[s];
      end
    end
  end

  p_plain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ev |=> $stable(plain));

endmodule

// File: rtl/row_decrypt_seq.sv
module row_decrypt_seq
  import rdec_pkg::*;
#(
  parameter int unsigned COLS      = 128,
  parameter int unsigned CHANNELS  = 16,
  parameter int unsigned PRE_CYC   = 1,
  parameter int unsigned PULSE_CYC = 2,
  localparam int unsigned GROUPS = COLS / CHANNELS,
  localparam int unsigned GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [COLS-1:0]     key_row,
  input  logic [CHANNELS-1:0] sense_in,
  output logic                busy,
  output logic                precharge_en,
  output logic                wl_pulse,
  output logic [GW-1:0]       grp_sel,
  output logic [COLS-1:0]     bl_drive,
  output logic [COLS-1:0]     sl_pre,
  output logic [COLS-1:0]     plain_row,
  output logic                plain_valid
);

  logic            accept;
  logic            cap_ev;
  logic            last_grp;
  logic [COLS-1:0] key_q;

  rdec_phase_ctl #(
    .GROUPS(GROUPS), .PRE_CYC(PRE_CYC), .PULSE_CYC(PULSE_CYC)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .precharge_en(precharge_en), .wl_pulse(wl_pulse), .grp(grp_sel),
    .cap_ev(cap_ev), .last_grp(last_grp)
  );

  rdec_bias_drv #(.COLS(COLS), .GROUPS(GROUPS)) u_bias (
    .active(busy), .grp(grp_sel), .key(key_q),
    .bl_drive(bl_drive), .sl_pre(sl_pre)
  );

  rdec_capture #(.COLS(COLS), .CHANNELS(CHANNELS)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_ev(cap_ev), .grp(grp_sel),
    .sense(sense_in), .plain(plain_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q       <= '0;
      plain_valid <= 1'b0;
    end else begin
      if (accept) key_q <= key_row;
      plain_valid <= cap_ev && last_grp;
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bl_drive == '0) && (sl_pre == '0));

  p_key_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(key_q));

  p_valid_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    plain_valid |=> !plain_valid);

  p_valid_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    plain_valid |-> $past(cap_ev && last_grp));

  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    plain_valid |-> !busy);

endmodule

// File: tb/row_decrypt_seq_bench.sv
module row_decrypt_seq_bench;

  localparam int COLS = 128;
  localparam int CH   = 16;
  localparam int G    = COLS / CH;
  localparam int PRE  = 1;
  localparam int PUL  = 2;
  localparam int STEP = PRE + PUL;
  localparam int LAT  = G * STEP;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [COLS-1:0] key_row = '0;
  logic [CH-1:0]   sense_in;
  logic            busy, precharge_en, wl_pulse, plain_valid;
  logic [2:0]      grp_sel;
  logic [COLS-1:0] bl_drive, sl_pre, plain_row;

  logic [COLS-1:0] ct_arr = '0;
  logic            wl_prev;
  int              n_cmp = 0;
  int              n_bad = 0;

  always #2 clk = ~clk;

  row_decrypt_seq u_row_decrypt_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .key_row(key_row),
    .sense_in(sense_in), .busy(busy), .precharge_en(precharge_en),
    .wl_pulse(wl_pulse), .grp_sel(grp_sel), .bl_drive(bl_drive),
    .sl_pre(sl_pre), .plain_row(plain_row), .plain_valid(plain_valid)
  );

  // cell model: low-threshold (ct 0) copies drain level, high keeps charge;
  // only the final pulse cycle gives settled data, otherwise inverted
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wl_prev <= 1'b0; else wl_prev <= wl_pulse;

  always_comb begin
    for (int s = 0; s < CH; s++) begin
      int c;
      logic v;
      c = s * G + int'(grp_sel);
      v = ct_arr[c] ? sl_pre[c] : bl_drive[c];
      sense_in[s] = (wl_pulse && wl_prev) ? v : ~v;
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [COLS-1:0] grp_mask(input int g);
    logic [COLS-1:0] m;
    for (int c = 0; c < COLS; c++) m[c] = ((c % G) == g);
    return m;
  endfunction

  function automatic logic [COLS-1:0] pat(input int seed);
    logic [COLS-1:0] p;
    for (int c = 0; c < COLS; c++) p[c] = (((c * seed + c / 5 + seed) % 7) < 3);
    return p;
  endfunction

  task automatic begin_row(input logic [COLS-1:0] ct, input logic [COLS-1:0] key);
    @(negedge clk);
    ct_arr  = ct;
    key_row = key;
    start   = 1'b1;
    @(posedge clk);
  endtask

  // mode 0 plain, 1 start while busy, 2 chained start across the last capture
  task automatic follow_row(input logic [COLS-1:0] ct, input logic [COLS-1:0] key,
                            input int mode, input logic [COLS-1:0] nct,
                            input logic [COLS-1:0] nkey);
    for (int k = 0; k < LAT; k++) begin
      int g;
      logic [COLS-1:0] m;
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (mode == 1 && k == 10) begin start = 1'b1; key_row = ~key; end
      if (mode == 1 && k == 11) start = 1'b0;
      if (mode == 2 && k == LAT - 1) begin start = 1'b1; key_row = nkey; end
      g = k / STEP;
      m = grp_mask(g);
      chk(grp_sel == 3'(g), "R4 grp_sel", COLS'(grp_sel), COLS'(g));
      chk(precharge_en == ((k % STEP) < PRE) && wl_pulse == ((k % STEP) >= PRE),
          "R5 phase", COLS'({precharge_en, wl_pulse}),
          COLS'({((k % STEP) < PRE), ((k % STEP) >= PRE)}));
      chk(bl_drive == (m & key), "R1 bl_drive", bl_drive, m & key);
      chk(sl_pre == (m & ~key), "R1/R2 sl_pre", sl_pre, m & ~key);
      chk(busy && !plain_valid, "R10 busy/R7 no early valid",
          COLS'({busy, plain_valid}), COLS'(2'b10));
    end
    @(negedge clk);
    chk(plain_valid == 1'b1, "R7 valid timing", COLS'(plain_valid), COLS'(1));
    chk(plain_row == (ct ^ key), "R3 plaintext", plain_row, ct ^ key);
    chk(!busy && bl_drive == '0 && sl_pre == '0, "R2 idle quiet/R10",
        bl_drive | sl_pre | COLS'(busy), '0);
    if (mode == 2) begin
      ct_arr = nct;
      @(posedge clk);
    end else begin
      @(negedge clk);
      chk(plain_valid == 1'b0 && busy == 1'b0, "R7 single pulse/R8 no restart",
          COLS'({plain_valid, busy}), '0);
    end
  endtask

  task automatic do_row(input logic [COLS-1:0] ct, input logic [COLS-1:0] key);
    begin_row(ct, key);
    follow_row(ct, key, 0, '0, '0);
  endtask

  initial begin
    logic [COLS-1:0] ct_x, key_x;
    for (int c = 0; c < COLS; c++) begin
      ct_x[c]  = c[3];
      key_x[c] = c[4];
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !plain_valid && !precharge_en && !wl_pulse && grp_sel == '0,
        "R9 reset ctl", COLS'({busy, plain_valid, precharge_en, wl_pulse, grp_sel}), '0);
    chk(bl_drive == '0 && sl_pre == '0 && plain_row == '0, "R9 reset data",
        bl_drive | sl_pre | plain_row, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 inputs while idle and no start: selects stay quiet
    key_row = '1;
    @(negedge clk);
    chk(bl_drive == '0 && sl_pre == '0 && !busy, "R2 idle key change",
        bl_drive | sl_pre, '0);

    do_row('0, '0);
    do_row('1, '1);
    do_row('0, '1);
    do_row('1, '0);
    do_row(ct_x, key_x);              // R3 all four ct/key combos in one row
    for (int sd = 1; sd < 9; sd++) do_row(pat(sd), pat(sd + 11));

    // R8 start with different key while busy
    begin_row(pat(4), pat(5));
    follow_row(pat(4), pat(5), 1, '0, '0);

    // R8/R7 start held across last capture into valid cycle: back to back
    begin_row(pat(6), pat(7));
    follow_row(pat(6), pat(7), 2, pat(8), ~pat(7));
    follow_row(pat(8), ~pat(7), 0, '0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule